// File: doc/BRIEF.md
# Block Erase Sequencer with Suspend

This block sits behind the command decoder of a sectored flash array and runs block erasure. A block-erase command opens a hold window and names a first block. Further block-erase commands that arrive before the window expires add their blocks to the erase set and restart the window. When the window closes, every selected block that is not protected goes through three phases in ascending block order: preprogram, erase and verify. Each phase is handed to the array through a request / done / fail handshake.

While the sequencer is busy, each status read flips status bit 6. A status read whose block is in the erase set also flips status bit 2. A ready/busy line is pulled low while the sequencer is busy.

An erase in progress can be suspended and later resumed from the same point. A suspend that arrives inside the hold window only restarts the window. A failed phase leaves the sequencer in a failed state until a reset command or a hardware reset. All timing is counted in microsecond ticks from an external tick input.

Top module: `blk_erase_seq`

## Requirements
- R1: The `mode` output encodes the state: 0 read, 1 hold window, 2 erasing, 3 suspend pending, 4 suspended, 5 failed, 6 all-protected wait. After hardware reset `mode` is 0, `rb_low` is 0 and `arr_req` is 0.
- R2: A block-erase command in read mode enters mode 1 with that block selected. No array request is made until HOLD_US ticks have passed since the last block-erase command.
- R3: A block-erase command in mode 1 adds its block to the set and restarts the hold count.
- R4: A reset, resume or other command in mode 1 returns to mode 0 with the set cleared, and no block of that set is erased.
- R5: Once erasing has started (mode 2), reset, other and block-erase commands have no effect. A hardware reset returns the sequencer to mode 0 at once.
- R6: Blocks are processed in ascending block number. Each block gets requests with `arr_phase` 0 (preprogram), then 1 (erase), then 2 (verify), one request per phase.
- R7: Blocks whose `prot_mask` bit is set are never requested. If every selected block is protected, the sequencer enters mode 6 and returns to mode 0 ALLPROT_US ticks after the last block-erase command, with no request made.
- R8: A done with fail set moves the sequencer to mode 5. Mode 5 is left only by a reset command (to mode 0) or by a hardware reset.
- R9: A suspend in mode 2 asserts `arr_hold` at once, enters mode 3, and reaches mode 4 after SUSP_US ticks. A resume in mode 4 returns to mode 2 and releases `arr_hold`, and the interrupted phase completes without a new request.
- R10: A suspend in mode 1 restarts the hold count and keeps mode 1, so further blocks may be added.
- R11: A status read flips `stat_t6` in modes 1, 2, 3, 5 and 6, and leaves it unchanged in modes 0 and 4. A status read whose block is in the set flips `stat_t2` in those busy modes and in mode 4.
- R12: `rb_low` is 1 in modes 1, 2, 3, 5 and 6, and 0 in modes 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cmd_erase | input | 1 | Block-erase command pulse |
| cmd_suspend | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_reset | input | 1 | Reset command pulse |
| cmd_other | input | 1 | Any other decoded command |
| cmd_blk | input | BLK_W | Block number carried by cmd_erase |
| prot_mask | input | NUM_BLOCKS | Per-block protection, 1 = protected |
| rd_stb | input | 1 | Status read strobe |
| rd_blk | input | BLK_W | Block addressed by the status read |
| arr_done | input | 1 | Array finished the requested phase |
| arr_fail | input | 1 | Qualifies arr_done: the phase failed |
| arr_req | output | 1 | One-cycle phase request to the array |
| arr_blk | output | BLK_W | Block of the request |
| arr_phase | output | 2 | Phase of the request: 0 preprogram, 1 erase, 2 verify |
| arr_hold | output | 1 | Pauses the array while suspending or suspended |
| stat_t6 | output | 1 | Busy toggle status bit |
| stat_t2 | output | 1 | Selected-block toggle status bit |
| rb_low | output | 1 | 1 = ready/busy line driven low (busy) |
| mode | output | 3 | Sequencer state, encoded as in R1 |

## Verification
A corrupted erase set shows at the array port as a wrong block, a missing block or a reordered request within one phase latency after the hold window closes. It also shows on `stat_t2` at the next status read of an affected block. A hold count that fails to restart shows as an early first request, or as an early change of `mode` from 1, within the hold window. A wrong state shows on `mode` and `rb_low` in the cycle after the causing command. Lost suspend progress shows as a repeated request after resume, and a failed state that is not sticky shows as `mode` leaving 5 without a reset command.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   typedef enum logic [2:0] {
      MD_READ     = 3'd0,
      MD_HOLD     = 3'd1,
      MD_ERASE    = 3'd2,
      MD_SUSPING  = 3'd3,
      MD_SUSP     = 3'd4,
      MD_FAIL     = 3'd5,
      MD_PROTWAIT = 3'd6
   } seq_mode_e;

   typedef enum logic [1:0] {
      PH_PRE = 2'd0,
      PH_ERS = 2'd1,
      PH_VFY = 2'd2
   } phase_e;

endpackage

// File: rtl/erase_us_timer.sv
// Saturating microsecond counter, restarted by clr.
module erase_us_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (tick && cnt != CNT_MAX)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/erase_blk_pick.sv
// Lowest-numbered set bit of the work mask.
module erase_blk_pick #(
   parameter int NUM_BLOCKS = 71,
   parameter int BLK_W      = 7
) (
   input  logic [NUM_BLOCKS-1:0] mask,
   output logic [BLK_W-1:0]      idx,
   output logic                  any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
         if (mask[i]) begin
            idx = BLK_W'(i);
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/erase_status.sv
// Toggle status bits advanced by status reads.
module erase_status (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic t6_en,
   input  logic t2_en,
   input  logic in_set,
   output logic t6,
   output logic t2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else if (rd_stb) begin
         if (t6_en)
            t6 <= ~t6;
         if (t2_en && in_set)
            t2 <= ~t2;
      end
   end

   // R11: no busy-toggle advance when disabled
   p_t6_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !t6_en) |=> $stable(t6));

   // R11: selected-block read in an enabled mode flips t2
   p_t2_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && t2_en && in_set) |=> (t2 != $past(t2)));

endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
   import erase_seq_pkg::*;
#(
   parameter int NUM_BLOCKS = 71,
   parameter int HOLD_US    = 50,
   parameter int SUSP_US    = 20,
   parameter int ALLPROT_US = 100,
   localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  us_tick,
   input  logic                  cmd_erase,
   input  logic                  cmd_suspend,
   input  logic                  cmd_resume,
   input  logic                  cmd_reset,
   input  logic                  cmd_other,
   input  logic [BLK_W-1:0]      cmd_blk,
   input  logic [NUM_BLOCKS-1:0] prot_mask,
   input  logic                  rd_stb,
   input  logic [BLK_W-1:0]      rd_blk,
   input  logic                  arr_done,
   input  logic                  arr_fail,
   output logic                  arr_req,
   output logic [BLK_W-1:0]      arr_blk,
   output logic [1:0]            arr_phase,
   output logic                  arr_hold,
   output logic                  stat_t6,
   output logic                  stat_t2,
   output logic                  rb_low,
   output logic [2:0]            mode
);
   localparam int MAX_HS = (HOLD_US > SUSP_US) ? HOLD_US : SUSP_US;
   localparam int MAX_T  = (ALLPROT_US > MAX_HS) ? ALLPROT_US : MAX_HS;
   localparam int CNT_W  = $clog2(MAX_T + 1);

   generate
      if (NUM_BLOCKS < 2)
         $error("NUM_BLOCKS must be at least 2");
      if (HOLD_US < 1 || SUSP_US < 1)
         $error("hold and suspend times must be at least one tick");
      if (ALLPROT_US <= HOLD_US)
         $error("ALLPROT_US must exceed HOLD_US");
   endgenerate

   seq_mode_e              state;
   phase_e                 ph;
   logic [NUM_BLOCKS-1:0]  sel_mask, work_mask, work_clr, blk_onehot;
   logic                   issued;
   logic [CNT_W-1:0]       tmr;
   logic                   tmr_clr;
   logic [BLK_W-1:0]       pick_idx;
   logic                   pick_any;
   logic                   fin_ok, fin_bad, hold_cmd_abort;
   logic                   busy_st, rd_in_set;

   // ---------------- helpers ----------------
   assign blk_onehot = ({1'b0, cmd_blk} < (BLK_W+1)'(NUM_BLOCKS))
                       ? (NUM_BLOCKS'(1) << cmd_blk) : '0;

   assign hold_cmd_abort = cmd_reset | cmd_resume | cmd_other;

   assign tmr_clr = (state == MD_READ  && cmd_erase)
                  | (state == MD_HOLD  && (cmd_erase || cmd_suspend))
                  | (state == MD_ERASE && cmd_suspend && !arr_done);

   erase_us_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (us_tick),
      .cnt   (tmr)
   );

   erase_blk_pick #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_pick (
      .mask (work_mask),
      .idx  (pick_idx),
      .any  (pick_any)
   );

   always_comb begin
      work_clr = work_mask;
      work_clr[arr_blk] = 1'b0;
   end

   assign fin_bad = arr_done && arr_fail;
   assign fin_ok  = arr_done && !arr_fail && (ph == PH_VFY) && (work_clr == '0);

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= MD_READ;
         sel_mask  <= '0;
         work_mask <= '0;
         ph        <= PH_PRE;
         issued    <= 1'b0;
         arr_req   <= 1'b0;
         arr_blk   <= '0;
         arr_phase <= 2'd0;
      end else begin
         arr_req <= 1'b0;
         unique case (state)
            MD_READ: begin
               if (cmd_erase) begin
                  sel_mask <= blk_onehot;
                  state    <= MD_HOLD;
               end
            end
            MD_HOLD: begin
               if (cmd_erase)
                  sel_mask <= sel_mask | blk_onehot;
               else if (cmd_suspend)
                  state <= MD_HOLD;
               else if (hold_cmd_abort) begin
                  sel_mask <= '0;
                  state    <= MD_READ;
               end else if (tmr >= CNT_W'(HOLD_US)) begin
                  if ((sel_mask & ~prot_mask) == '0)
                     state <= MD_PROTWAIT;
                  else begin
                     work_mask <= sel_mask & ~prot_mask;
                     ph        <= PH_PRE;
                     issued    <= 1'b0;
                     state     <= MD_ERASE;
                  end
               end
            end
            MD_PROTWAIT: begin
               if (tmr >= CNT_W'(ALLPROT_US)) begin
                  sel_mask <= '0;
                  state    <= MD_READ;
               end
            end
            MD_ERASE, MD_SUSPING: begin
               if (arr_done) begin
                  issued <= 1'b0;
                  if (!arr_fail) begin
                     if (ph == PH_VFY) begin
                        work_mask <= work_clr;
                        ph        <= PH_PRE;
                     end else
                        ph <= phase_e'(ph + 2'd1);
                  end
               end
               if (fin_bad)
                  state <= MD_FAIL;
               else if (fin_ok) begin
                  sel_mask <= '0;
                  state    <= MD_READ;
               end else if (state == MD_ERASE && cmd_suspend)
                  state <= MD_SUSPING;
               else if (state == MD_SUSPING && tmr >= CNT_W'(SUSP_US))
                  state <= MD_SUSP;
               if (state == MD_ERASE && !issued && pick_any && !arr_done) begin
                  arr_req   <= 1'b1;
                  arr_blk   <= pick_idx;
                  arr_phase <= ph;
                  issued    <= 1'b1;
               end
            end
            MD_SUSP: begin
               if (cmd_resume)
                  state <= MD_ERASE;
            end
            MD_FAIL: begin
               if (cmd_reset) begin
                  sel_mask  <= '0;
                  work_mask <= '0;
                  ph        <= PH_PRE;
                  issued    <= 1'b0;
                  state     <= MD_READ;
               end
            end
            default: state <= MD_READ;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign busy_st  = (state == MD_HOLD) || (state == MD_ERASE) || (state == MD_SUSPING)
                   || (state == MD_FAIL) || (state == MD_PROTWAIT);
   assign rb_low   = busy_st;
   assign arr_hold = (state == MD_SUSPING) || (state == MD_SUSP);
   assign mode     = state;

   assign rd_in_set = ({1'b0, rd_blk} < (BLK_W+1)'(NUM_BLOCKS)) ? sel_mask[rd_blk] : 1'b0;

   erase_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (rd_stb),
      .t6_en  (busy_st),
      .t2_en  (busy_st || state == MD_SUSP),
      .in_set (rd_in_set),
      .t6     (stat_t6),
      .t2     (stat_t2)
   );

   // ---------------- assertions ----------------
   // R6: requests are launched only from the erasing state
   p_req_from_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> ($past(state) == MD_ERASE));

   // R7: a protected block is never requested
   p_req_unprot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> !prot_mask[arr_blk]);

   // R8: failed state persists without a reset command
   p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MD_FAIL && !cmd_reset) |=> (state == MD_FAIL));

   // R5: erasing ignores everything except suspend and array completion
   p_ignore_cmds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MD_ERASE && !cmd_suspend && !arr_done) |=> (state == MD_ERASE));

   // R9: no new request while suspended
   p_no_req_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MD_SUSP) |-> !arr_req);

   // R12: ready/busy released while suspended
   p_rb_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MD_SUSP) |-> !rb_low);

   // R10: suspend in the hold window stays in the window
   p_hold_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MD_HOLD && cmd_suspend && !cmd_erase) |=> (state == MD_HOLD));

endmodule

// File: tb/test_blk_erase_seq.sv
module test_blk_erase_seq;
   localparam int NB    = 71;
   localparam int BW    = $clog2(NB);
   localparam int HOLD  = 8;
   localparam int SUSP  = 3;
   localparam int APROT = 20;
   localparam int LAT   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   logic cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0, cmd_other = 0;
   logic [BW-1:0] cmd_blk = '0;
   logic [NB-1:0] prot_mask = '0;
   logic rd_stb = 0;
   logic [BW-1:0] rd_blk = '0;
   logic arr_done, arr_fail;
   logic arr_req, arr_hold, stat_t6, stat_t2, rb_low;
   logic [BW-1:0] arr_blk;
   logic [1:0] arr_phase;
   logic [2:0] mode;

   int errors = 0, checks = 0;
   int tick_cnt = 0;
   int fail_blk = -1;

   blk_erase_seq #(.NUM_BLOCKS(NB), .HOLD_US(HOLD), .SUSP_US(SUSP), .ALLPROT_US(APROT))
   i_blk_erase_seq (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
      .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
      .cmd_reset(cmd_reset), .cmd_other(cmd_other), .cmd_blk(cmd_blk),
      .prot_mask(prot_mask), .rd_stb(rd_stb), .rd_blk(rd_blk),
      .arr_done(arr_done), .arr_fail(arr_fail), .arr_req(arr_req),
      .arr_blk(arr_blk), .arr_phase(arr_phase), .arr_hold(arr_hold),
      .stat_t6(stat_t6), .stat_t2(stat_t2), .rb_low(rb_low), .mode(mode)
   );

   always #10 clk = ~clk;

   always @(negedge clk) us_tick <= ~us_tick;
   always @(posedge clk) if (us_tick) tick_cnt <= tick_cnt + 1;

   // array model with request log
   int lg_blk [128];
   int lg_ph  [128];
   int lg_n = 0;
   logic m_busy;
   int m_cnt, m_blk, m_ph;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0; arr_done <= 1'b0; arr_fail <= 1'b0; m_cnt <= 0;
      end else begin
         arr_done <= 1'b0;
         arr_fail <= 1'b0;
         if (arr_req) begin
            m_busy <= 1'b1; m_cnt <= LAT; m_blk <= int'(arr_blk); m_ph <= int'(arr_phase);
            lg_blk[lg_n % 128] <= int'(arr_blk);
            lg_ph[lg_n % 128]  <= int'(arr_phase);
            lg_n <= lg_n + 1;
         end else if (m_busy && !arr_hold) begin
            if (m_cnt == 1) begin
               m_busy <= 1'b0; arr_done <= 1'b1;
               arr_fail <= (m_blk == fail_blk) && (m_ph == 2);
            end else
               m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_mode(input int exp, input string req);
      chk(int'(mode) == exp, req, int'(mode), exp);
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      int t0 = tick_cnt;
      while (tick_cnt - t0 < n) @(negedge clk);
   endtask

   task automatic wait_mode(input int m, input string req);
      int k = 0;
      while (int'(mode) != m && k < 3000) begin @(negedge clk); k++; end
      chk(int'(mode) == m, req, int'(mode), m);
   endtask

   task automatic do_erase(input int b);
      cmd_blk = BW'(b); cmd_erase = 1; @(negedge clk); cmd_erase = 0;
   endtask
   task automatic do_susp();   cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; endtask
   task automatic do_resume(); cmd_resume = 1;  @(negedge clk); cmd_resume = 0;  endtask
   task automatic do_reset();  cmd_reset = 1;   @(negedge clk); cmd_reset = 0;   endtask
   task automatic do_other();  cmd_other = 1;   @(negedge clk); cmd_other = 0;   endtask
   task automatic do_read(input int b);
      rd_blk = BW'(b); rd_stb = 1; @(negedge clk); rd_stb = 0;
   endtask

   task automatic chk_entry(input int k, input int b, input int p, input string req);
      chk(lg_blk[k % 128] == b, {req, " block"}, lg_blk[k % 128], b);
      chk(lg_ph[k % 128] == p,  {req, " phase"}, lg_ph[k % 128], p);
   endtask

   task automatic hw_reset();
      rst_n = 0; cycles(2); rst_n = 1; cycles(2);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk_mode(0, "R1 reset mode");
      chk(rb_low == 0, "R1 reset rb_low", rb_low, 0);
      chk(arr_req == 0, "R1 reset arr_req", arr_req, 0);
   endtask

   task automatic t_single();
      int base = lg_n;
      do_erase(5);
      chk_mode(1, "R2 enter hold");
      chk(rb_low == 1, "R12 busy in hold", rb_low, 1);
      wait_ticks(HOLD - 2);
      chk_mode(1, "R2 still hold");
      chk(lg_n == base, "R2 no early request", lg_n - base, 0);
      wait_mode(2, "R2 erase starts");
      wait_mode(0, "R6 back to read");
      chk(lg_n - base == 3, "R6 request count", lg_n - base, 3);
      for (int p = 0; p < 3; p++) chk_entry(base + p, 5, p, "R6 single");
   endtask

   task automatic t_multi();
      int base = lg_n;
      do_erase(40);
      wait_ticks(HOLD - 2);
      do_erase(3);
      wait_ticks(HOLD - 2);
      chk_mode(1, "R3 hold restarted");
      chk(lg_n == base, "R3 no request yet", lg_n - base, 0);
      wait_mode(0, "R3 multi done");
      chk(lg_n - base == 6, "R6 multi count", lg_n - base, 6);
      for (int p = 0; p < 3; p++) chk_entry(base + p, 3, p, "R6 ascending first");
      for (int p = 0; p < 3; p++) chk_entry(base + 3 + p, 40, p, "R6 ascending second");
   endtask

   task automatic t_abort_hold();
      int base = lg_n;
      do_erase(7);
      do_other();
      chk_mode(0, "R4 other aborts hold");
      wait_ticks(HOLD + 4);
      chk(lg_n == base, "R4 nothing erased", lg_n - base, 0);
      do_erase(8);
      do_resume();
      chk_mode(0, "R4 resume aborts hold");
      wait_ticks(HOLD + 4);
      chk(lg_n == base, "R4 nothing erased after resume", lg_n - base, 0);
   endtask

   task automatic t_protect();
      int base = lg_n;
      prot_mask = '0; prot_mask[10] = 1'b1;
      do_erase(10); do_erase(11);
      wait_mode(2, "R7 erase start");
      wait_mode(0, "R7 done");
      chk(lg_n - base == 3, "R7 protected skipped", lg_n - base, 3);
      chk_entry(base, 11, 0, "R7 only unprotected");
      base = lg_n;
      do_erase(10);
      wait_ticks(HOLD + 2);
      chk_mode(6, "R7 all-protected wait");
      chk(rb_low == 1, "R12 busy in wait", rb_low, 1);
      wait_ticks(APROT - HOLD - 6);
      chk_mode(6, "R7 still waiting");
      wait_ticks(8);
      chk_mode(0, "R7 back to read");
      chk(lg_n == base, "R7 no request", lg_n - base, 0);
      prot_mask = '0;
   endtask

   task automatic t_ignore_and_status();
      int base = lg_n;
      logic t6a, t2a;
      do_erase(2);
      wait_mode(2, "R5 erasing");
      cycles(2);
      do_reset(); do_other(); do_erase(9);
      chk_mode(2, "R5 commands ignored");
      t6a = stat_t6; t2a = stat_t2;
      do_read(2);
      chk(stat_t6 != t6a, "R11 t6 flips busy", stat_t6, !t6a);
      chk(stat_t2 != t2a, "R11 t2 flips in set", stat_t2, !t2a);
      t6a = stat_t6; t2a = stat_t2;
      do_read(9);
      chk(stat_t6 != t6a, "R11 t6 flips any block", stat_t6, !t6a);
      chk(stat_t2 == t2a, "R11 t2 steady outside set", stat_t2, t2a);
      wait_mode(0, "R5 erase finishes");
      chk(lg_n - base == 3, "R5 added block ignored", lg_n - base, 3);
      t6a = stat_t6;
      do_read(2);
      chk(stat_t6 == t6a, "R11 t6 steady in read", stat_t6, t6a);
   endtask

   task automatic t_hwreset();
      int base;
      do_erase(12);
      wait_mode(2, "R5 erasing before reset");
      cycles(3);
      hw_reset();
      chk_mode(0, "R5 hw reset aborts");
      base = lg_n;
      cycles(60);
      chk(lg_n == base, "R5 no request after abort", lg_n - base, 0);
   endtask

   task automatic t_suspend();
      int base = lg_n, b2;
      logic t6a, t2a;
      do_erase(20);
      wait_mode(2, "R9 erasing");
      while (lg_n == base) @(negedge clk);
      cycles(2);
      do_susp();
      chk_mode(3, "R9 suspend pending");
      chk(arr_hold == 1, "R9 hold asserted", arr_hold, 1);
      wait_ticks(SUSP + 2);
      chk_mode(4, "R9 suspended");
      chk(rb_low == 0, "R12 released in suspend", rb_low, 0);
      b2 = lg_n;
      cycles(40);
      chk(lg_n == b2, "R9 array paused", lg_n - b2, 0);
      do_other(); do_reset();
      chk_mode(4, "R9 stays suspended");
      t6a = stat_t6; t2a = stat_t2;
      do_read(20);
      chk(stat_t6 == t6a, "R11 t6 frozen in suspend", stat_t6, t6a);
      chk(stat_t2 != t2a, "R11 t2 flips in suspend", stat_t2, !t2a);
      t2a = stat_t2;
      do_read(21);
      chk(stat_t2 == t2a, "R11 t2 steady other block", stat_t2, t2a);
      do_resume();
      chk_mode(2, "R9 resumed");
      chk(rb_low == 1, "R12 busy after resume", rb_low, 1);
      chk(arr_hold == 0, "R9 hold released", arr_hold, 0);
      wait_mode(0, "R9 completes");
      chk(lg_n - base == 3, "R9 no repeated request", lg_n - base, 3);
      for (int p = 0; p < 3; p++) chk_entry(base + p, 20, p, "R9 phases");
   endtask

   task automatic t_susp_hold();
      int base = lg_n;
      do_erase(30);
      wait_ticks(HOLD - 2);
      do_susp();
      chk_mode(1, "R10 suspend keeps hold");
      wait_ticks(HOLD - 2);
      chk_mode(1, "R10 window restarted");
      do_erase(31);
      wait_mode(0, "R10 done");
      chk(lg_n - base == 6, "R10 both blocks", lg_n - base, 6);
      chk_entry(base, 30, 0, "R10 first");
      chk_entry(base + 3, 31, 0, "R10 added");
   endtask

   task automatic t_fail();
      fail_blk = 50;
      do_erase(50);
      wait_mode(5, "R8 fail state");
      chk(rb_low == 1, "R12 busy in fail", rb_low, 1);
      cycles(50);
      do_other(); do_resume(); do_erase(3);
      chk_mode(5, "R8 sticky");
      do_reset();
      chk_mode(0, "R8 reset command exits");
      fail_blk = -1;
   endtask

   initial begin
      cycles(3);
      rst_n = 1;
      cycles(2);
      t_reset();
      t_single();
      t_multi();
      t_abort_hold();
      t_protect();
      t_ignore_and_status();
      t_hwreset();
      t_suspend();
      t_susp_hold();
      t_fail();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule